// File: doc/BRIEF.md
# Thread Clustering and Rank Shuffler

This block gives every hardware thread a distinct priority level for a memory scheduler. At the end of each quantum it samples three counters per thread: memory accesses, row-buffer hits and bank-level parallelism. The least memory-intensive threads go into a latency-sensitive group, and the rest go into a bandwidth-sensitive group. Every thread in the latency-sensitive group outranks every thread in the bandwidth-sensitive group.

Inside the bandwidth-sensitive group, threads are ordered by a niceness score. A thread is nicer when its bank-level parallelism is high and its row-hit rate is low. The order is then permuted at a fixed interval that is shorter than the quantum. When the niceness spread in the group is wide, the block uses a deterministic rotation (insertion shuffling). Otherwise it uses LFSR-driven random pair swaps. The scheduler reads the result as a flat vector of priority numbers, where a larger number means a more urgent thread.

Top module: `tcs_rank_shuffler`

## Requirements
- R1: While reset is held and until the first quantum boundary, no thread is latency-sensitive, the mode output is 0 (random), and thread i has priority N-1-i.
- R2: Counting from the first clock edge after reset release, the inputs are sampled and the cluster, mode, ranks and order are recomputed only at every QUANT_CYC-th edge. Between those edges, lat_mask_o and ins_mode_o hold their values.
- R3: Threads are sorted by access count in ascending order, with ties broken by the lower index first. A thread is latency-sensitive when 16 times the sum of the accesses of itself and of all threads sorted before it is at most LAT_NUM times the total accesses. If the total is zero, every thread is latency-sensitive.
- R4: A latency-sensitive thread with sorted intensity position r (0 is the lowest intensity) gets priority N-1-r. Every latency-sensitive thread outranks every bandwidth-sensitive thread.
- R5: Niceness equals the parallelism rank minus the hit-rate rank. Each rank is the count of other threads that are strictly smaller, plus the equal threads with a lower index. Hit rates are compared by the cross products hit_j*acc_i versus hit_i*acc_j.
- R6: Right after a quantum boundary, the B bandwidth-sensitive threads take slots 0..B-1 in descending niceness, with ties broken by the lower index first. A thread in slot s has priority B-1-s.
- R7: The mode output becomes 1 (insertion) when B is at least 2 and the spread of niceness between the highest and lowest thread in the bandwidth-sensitive group is at least GAP_TH. Otherwise it is 0 (random).
- R8: A shuffle tick falls on every edge where the edge count since the last quantum boundary is a nonzero multiple of SHUF_CYC. In insertion mode, each tick moves every bandwidth-sensitive thread from slot s to slot (s+1) mod B.
- R9: In random mode, each tick swaps the threads in slots p = L[1:0] mod B and q = L[3:2] mod B, where L is the LFSR value before the tick. The 8-bit LFSR starts at 8'hA5 and advances on every tick as L <= {L[6:0], ^(L & 8'hB8)}. Latency-sensitive priorities never change on a tick.
- R10: At every cycle, the N priority values form a permutation of 0..N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_cnt_i | input | N*CW | Per-thread access counts, thread i in bits [i*CW +: CW] |
| hit_cnt_i | input | N*CW | Per-thread row-buffer hit counts |
| blp_cnt_i | input | N*CW | Per-thread bank-level parallelism measure |
| prio_o | output | N*PW | Per-thread priority, larger value is more urgent |
| lat_mask_o | output | N | Bit i set when thread i is latency-sensitive |
| ins_mode_o | output | 1 | 1 = insertion shuffling, 0 = random shuffling |

## Verification
The bench applies one fresh counter pattern per quantum and compares every output at every cycle against an arithmetic model.

- An all-zero pattern checks the empty-total rule.
- Equal access counts place a cumulative share exactly on the threshold, which separates "at most" from "less than" in R3.
- A single dominant thread checks the case where the bandwidth-sensitive group is small.
- Saturated counters give ties everywhere, which exercises the index tie-breaks.
- Pseudo-random patterns reach both shuffle modes and every group size. Over three shuffle ticks per quantum, they distinguish a rotation from a swap and a correct LFSR step from a wrong one.

// File: rtl/tcs_pkg.sv
// Shared definitions for the thread clustering and rank shuffler.
package tcs_pkg;
    // Shuffle method selected for the bandwidth-sensitive group.
    typedef enum logic {
        SHUF_RANDOM = 1'b0,
        SHUF_INSERT = 1'b1
    } shuf_mode_e;
endpackage

// File: rtl/tcs_timer.sv
// Quantum and shuffle interval timer.
// Raises q_tick once every QUANT_CYC cycles. Raises s_tick every SHUF_CYC cycles
// after a quantum boundary, but never together with q_tick.
// Assumes 2 <= SHUF_CYC < QUANT_CYC.
module tcs_timer #(
    parameter int QUANT_CYC = 16,
    parameter int SHUF_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic q_tick,
    output logic s_tick
);
    localparam int QW = $clog2(QUANT_CYC);
    localparam int SW = $clog2(SHUF_CYC);

    logic [QW-1:0] qcnt;
    logic [SW-1:0] scnt;

    assign q_tick = (qcnt == QW'(QUANT_CYC - 1));
    assign s_tick = (scnt == SW'(SHUF_CYC - 1)) && !q_tick;

    // Quantum counter: wraps at the quantum length.
    always_ff @(posedge clk) begin
        if (!rst_n)      qcnt <= '0;
        else if (q_tick) qcnt <= '0;
        else             qcnt <= qcnt + QW'(1);
    end

    // Shuffle counter: restarts at each quantum boundary and wraps at the interval.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 scnt <= '0;
        else if (q_tick)                            scnt <= '0;
        else if (scnt == SW'(SHUF_CYC - 1))         scnt <= '0;
        else                                        scnt <= scnt + SW'(1);
    end
endmodule

// File: rtl/tcs_quantum_eval.sv
// Combinational evaluation done at a quantum boundary.
// From the raw counters it produces:
//   - the intensity position of each thread,
//   - latency-cluster membership,
//   - the niceness-based starting slot of each bandwidth-sensitive thread,
//   - the bandwidth-sensitive group size,
//   - the shuffle mode.
// Assumes N <= 2**PW. The result is only registered when q_tick is high.
module tcs_quantum_eval
    import tcs_pkg::*;
#(
    parameter int N       = 4,
    parameter int CW      = 6,
    parameter int PW      = 2,
    parameter int CNTW    = 3,
    parameter int FW      = 4,
    parameter int LAT_NUM = 8,
    parameter int GAP_TH  = 3
) (
    input  logic [N*CW-1:0] acc_flat,
    input  logic [N*CW-1:0] hit_flat,
    input  logic [N*CW-1:0] blp_flat,
    output logic [N*PW-1:0] irank_flat,
    output logic [N*PW-1:0] base_flat,
    output logic [N-1:0]    lat,
    output logic [CNTW-1:0] nbw,
    output shuf_mode_e      mode
);
    localparam int SUMW = CW + CNTW;
    localparam int LHW  = SUMW + FW + 1;
    localparam int PRW  = 2 * CW;
    localparam int NW   = PW + 1;

    logic [CW-1:0]   acc [N];
    logic [CW-1:0]   hit [N];
    logic [CW-1:0]   blp [N];
    logic [PW-1:0]   irank [N];
    logic [PW-1:0]   hrank [N];
    logic [PW-1:0]   brank [N];
    logic [NW-1:0]   nice [N];
    logic [PW-1:0]   base [N];
    logic [SUMW-1:0] pre [N];
    logic [SUMW-1:0] tot;
    logic [NW-1:0]   nmax, nmin;

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign acc[g] = acc_flat[g*CW +: CW];
        assign hit[g] = hit_flat[g*CW +: CW];
        assign blp[g] = blp_flat[g*CW +: CW];
        assign irank_flat[g*PW +: PW] = irank[g];
        assign base_flat[g*PW +: PW]  = base[g];
    end

    // Intensity, hit-rate and parallelism ranks; ties go to the lower index.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            irank[i] = '0;
            hrank[i] = '0;
            brank[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i) begin
                    if (acc[j] < acc[i] || (acc[j] == acc[i] && j < i))
                        irank[i] = irank[i] + PW'(1);
                    if ((PRW'(hit[j]) * PRW'(acc[i]) < PRW'(hit[i]) * PRW'(acc[j])) ||
                        (PRW'(hit[j]) * PRW'(acc[i]) == PRW'(hit[i]) * PRW'(acc[j]) && j < i))
                        hrank[i] = hrank[i] + PW'(1);
                    if (blp[j] < blp[i] || (blp[j] == blp[i] && j < i))
                        brank[i] = brank[i] + PW'(1);
                end
            end
            nice[i] = NW'(brank[i]) + NW'(N - 1) - NW'(hrank[i]);
        end
    end

    // Cumulative-share test that decides latency-cluster membership.
    always_comb begin
        tot = '0;
        for (int j = 0; j < N; j++) tot = tot + SUMW'(acc[j]);
        for (int i = 0; i < N; i++) begin
            pre[i] = '0;
            for (int j = 0; j < N; j++)
                if (irank[j] <= irank[i]) pre[i] = pre[i] + SUMW'(acc[j]);
            lat[i] = ((LHW'(pre[i]) << FW) <= LHW'(tot) * LHW'(LAT_NUM));
        end
    end

    // Niceness ordering inside the bandwidth group, group size and spread.
    always_comb begin
        nbw  = '0;
        nmax = '0;
        nmin = '1;
        for (int i = 0; i < N; i++) begin
            base[i] = '0;
            if (!lat[i]) begin
                nbw = nbw + CNTW'(1);
                if (nice[i] > nmax) nmax = nice[i];
                if (nice[i] < nmin) nmin = nice[i];
                for (int j = 0; j < N; j++)
                    if (j != i && !lat[j] &&
                        (nice[j] > nice[i] || (nice[j] == nice[i] && j < i)))
                        base[i] = base[i] + PW'(1);
            end
        end
        mode = ((nbw > CNTW'(1)) && ((int'(nmax) - int'(nmin)) >= GAP_TH))
               ? SHUF_INSERT : SHUF_RANDOM;
    end
endmodule

// File: rtl/tcs_shuffler.sv
// Slot register for the bandwidth-sensitive threads.
// On q_tick it loads the niceness order. On s_tick it either rotates every
// bandwidth thread down one slot or swaps two LFSR-chosen slots.
// The LFSR advances on every s_tick. Slots of latency-sensitive threads are
// don't-care.
module tcs_shuffler
    import tcs_pkg::*;
#(
    parameter int             N    = 4,
    parameter int             PW   = 2,
    parameter int             CNTW = 3,
    parameter int             LW   = 8,
    parameter logic [LW-1:0]  TAPS = 8'hB8,
    parameter logic [LW-1:0]  SEED = 8'hA5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_tick,
    input  logic            s_tick,
    input  logic [N-1:0]    lat_q,
    input  logic [CNTW-1:0] nbw_q,
    input  shuf_mode_e      mode_q,
    input  logic [N*PW-1:0] base_flat,
    output logic [N*PW-1:0] slot_flat
);
    logic [PW-1:0] slot [N];
    logic [PW-1:0] nxt  [N];
    logic [LW-1:0] lfsr;
    logic [PW-1:0] pa, pb;

    for (genvar g = 0; g < N; g++) begin : g_pack
        assign slot_flat[g*PW +: PW] = slot[g];
    end

    // Pick the two swap positions from the current LFSR value.
    always_comb begin
        pa = '0;
        pb = '0;
        if (nbw_q != '0) begin
            pa = PW'(CNTW'(lfsr[PW-1:0]) % nbw_q);
            pb = PW'(CNTW'(lfsr[2*PW-1:PW]) % nbw_q);
        end
    end

    // Next slot of every thread for this cycle.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            nxt[i] = slot[i];
            if (q_tick) begin
                nxt[i] = base_flat[i*PW +: PW];
            end else if (s_tick && nbw_q != '0 && !lat_q[i]) begin
                if (mode_q == SHUF_INSERT)
                    nxt[i] = (CNTW'(slot[i]) == nbw_q - CNTW'(1)) ? '0 : slot[i] + PW'(1);
                else if (slot[i] == pa)
                    nxt[i] = pb;
                else if (slot[i] == pb)
                    nxt[i] = pa;
            end
        end
    end

    // Slot state, identity order at reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) slot[i] <= PW'(i);
            else        slot[i] <= nxt[i];
        end
    end

    // Shuffle LFSR, stepped once per shuffle tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      lfsr <= SEED;
        else if (s_tick) lfsr <= {lfsr[LW-2:0], ^(lfsr & TAPS)};
    end
endmodule

// File: rtl/tcs_rank_shuffler.sv
// Thread clustering and rank shuffler (top).
// Registers the quantum evaluation and keeps the shuffled bandwidth order.
// Maps both to a flat per-thread priority vector.
// Assumes counters are stable at the quantum boundary and N <= 2**PW.
module tcs_rank_shuffler
    import tcs_pkg::*;
#(
    parameter int            N         = 4,
    parameter int            CW        = 6,
    parameter int            QUANT_CYC = 16,
    parameter int            SHUF_CYC  = 4,
    parameter int            FW        = 4,
    parameter int            LAT_NUM   = 8,
    parameter int            GAP_TH    = 3,
    parameter int            LW        = 8,
    parameter logic [LW-1:0] TAPS      = 8'hB8,
    parameter logic [LW-1:0] SEED      = 8'hA5,
    localparam int           PW        = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N*CW-1:0] acc_cnt_i,
    input  logic [N*CW-1:0] hit_cnt_i,
    input  logic [N*CW-1:0] blp_cnt_i,
    output logic [N*PW-1:0] prio_o,
    output logic [N-1:0]    lat_mask_o,
    output logic            ins_mode_o
);
    localparam int CNTW = $clog2(N + 1);

    logic            q_tick, s_tick;
    logic [N*PW-1:0] irank_c, base_c, slot_flat;
    logic [N-1:0]    lat_c, lat_q;
    logic [CNTW-1:0] nbw_c, nbw_q;
    shuf_mode_e      mode_c, mode_q;
    logic [PW-1:0]   irank_q [N];

    tcs_timer #(.QUANT_CYC(QUANT_CYC), .SHUF_CYC(SHUF_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .q_tick(q_tick), .s_tick(s_tick)
    );

    tcs_quantum_eval #(
        .N(N), .CW(CW), .PW(PW), .CNTW(CNTW), .FW(FW),
        .LAT_NUM(LAT_NUM), .GAP_TH(GAP_TH)
    ) u_eval (
        .acc_flat(acc_cnt_i), .hit_flat(hit_cnt_i), .blp_flat(blp_cnt_i),
        .irank_flat(irank_c), .base_flat(base_c), .lat(lat_c),
        .nbw(nbw_c), .mode(mode_c)
    );

    tcs_shuffler #(
        .N(N), .PW(PW), .CNTW(CNTW), .LW(LW), .TAPS(TAPS), .SEED(SEED)
    ) u_shuf (
        .clk(clk), .rst_n(rst_n), .q_tick(q_tick), .s_tick(s_tick),
        .lat_q(lat_q), .nbw_q(nbw_q), .mode_q(mode_q),
        .base_flat(base_c), .slot_flat(slot_flat)
    );

    // Cluster state, captured only at a quantum boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= '0;
            nbw_q  <= CNTW'(N);
            mode_q <= SHUF_RANDOM;
        end else if (q_tick) begin
            lat_q  <= lat_c;
            nbw_q  <= nbw_c;
            mode_q <= mode_c;
        end
    end

    // Intensity positions, captured only at a quantum boundary.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n)      irank_q[i] <= '0;
            else if (q_tick) irank_q[i] <= irank_c[i*PW +: PW];
        end
    end

    // Priority mapping: latency threads on top, bandwidth threads by slot.
    for (genvar g = 0; g < N; g++) begin : g_prio
        assign prio_o[g*PW +: PW] = lat_q[g]
            ? PW'(N - 1) - irank_q[g]
            : PW'(nbw_q - CNTW'(1) - CNTW'(slot_flat[g*PW +: PW]));
    end

    assign lat_mask_o = lat_q;
    assign ins_mode_o = mode_q;
endmodule

// File: rtl/tcs_rank_shuffler_chk.sv
// Assertion checker for tcs_rank_shuffler, attached by bind below.
// Watches the output vectors against the internal quantum and shuffle ticks.
module tcs_rank_shuffler_chk #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          q_tick,
    input logic          s_tick,
    input logic [N*PW-1:0] prio_o,
    input logic [N-1:0]  lat_mask_o,
    input logic          ins_mode_o
);
    logic [N-1:0]    seen;
    logic [N*PW-1:0] lat_view;

    // Collect which priority values are present and the latency-thread priorities.
    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) begin
            seen[prio_o[i*PW +: PW]] = 1'b1;
            lat_view[i*PW +: PW] = lat_mask_o[i] ? prio_o[i*PW +: PW] : '0;
        end
    end

    assert_prio_perm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        &seen);

    assert_cluster_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !q_tick |=> ($stable(lat_mask_o) && $stable(ins_mode_o)));

    assert_prio_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_tick && !s_tick) |=> $stable(prio_o));

    assert_shuffle_spares_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_tick |=> $stable(lat_view));

    for (genvar i = 0; i < N; i++) begin : g_i
        for (genvar j = 0; j < N; j++) begin : g_j
            if (i != j) begin : g_pair
                assert_lat_above_bw_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (lat_mask_o[i] && !lat_mask_o[j]) |->
                    (prio_o[i*PW +: PW] > prio_o[j*PW +: PW]));
            end
        end
    end
endmodule

bind tcs_rank_shuffler tcs_rank_shuffler_chk #(.N(N), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .q_tick(q_tick), .s_tick(s_tick),
    .prio_o(prio_o), .lat_mask_o(lat_mask_o), .ins_mode_o(ins_mode_o)
);

// File: tb/tcs_rank_shuffler_bench.sv
// Sweep bench: one counter pattern per quantum, every output compared every cycle.
module tcs_rank_shuffler_bench;
    localparam int N  = 4;
    localparam int CW = 6;
    localparam int Q  = 16;
    localparam int S  = 4;
    localparam int NQ = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N*CW-1:0] acc_v, hit_v, blp_v;
    logic [N*2-1:0]  prio;
    logic [N-1:0]    latm;
    logic            insm;

    int a [N];
    int h [N];
    int b [N];
    int m_lat [N];
    int m_ir [N];
    int m_slot [N];
    int m_nbw, m_ins;
    logic [7:0]  m_lfsr;
    logic [31:0] rs = 32'h1234_5678;
    int n_vec = 0, n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tcs_rank_shuffler u_tcs_rank_shuffler (
        .clk(clk), .rst_n(rst_n), .acc_cnt_i(acc_v), .hit_cnt_i(hit_v),
        .blp_cnt_i(blp_v), .prio_o(prio), .lat_mask_o(latm), .ins_mode_o(insm)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            acc_v[i*CW +: CW] = CW'(a[i]);
            hit_v[i*CW +: CW] = CW'(h[i]);
            blp_v[i*CW +: CW] = CW'(b[i]);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int rnd();
        rs = rs * 32'd1103515245 + 32'd12345;
        return int'(rs[21:16]);
    endfunction

    task automatic set_pattern(input int p);
        for (int i = 0; i < N; i++) begin
            case (p)
                0: begin a[i] = 0;  h[i] = 0;          b[i] = 0;     end
                1: begin a[i] = 50; h[i] = 40 - 10*i;  b[i] = 10*i;  end
                2: begin a[i] = (i == 2) ? 63 : 1; h[i] = i; b[i] = 63 - 20*i; end
                3: begin a[i] = 63; h[i] = 63;         b[i] = 63;    end
                default: begin a[i] = rnd(); h[i] = rnd(); b[i] = rnd(); end
            endcase
        end
    endtask

    // Quantum recomputation straight from the requirement text (R3, R5, R6, R7).
    task automatic model_quantum();
        int tot, pre, br, hr, mx, mn, sl;
        int nice [N];
        tot = 0;
        for (int i = 0; i < N; i++) tot += a[i];
        for (int i = 0; i < N; i++) begin
            m_ir[i] = 0;
            for (int j = 0; j < N; j++)
                if (j != i && (a[j] < a[i] || (a[j] == a[i] && j < i))) m_ir[i]++;
        end
        for (int i = 0; i < N; i++) begin
            pre = 0;
            for (int j = 0; j < N; j++) if (m_ir[j] <= m_ir[i]) pre += a[j];
            m_lat[i] = (pre * 16 <= tot * 8) ? 1 : 0;
        end
        for (int i = 0; i < N; i++) begin
            br = 0; hr = 0;
            for (int j = 0; j < N; j++) begin
                if (j == i) continue;
                if (b[j] < b[i] || (b[j] == b[i] && j < i)) br++;
                if (h[j]*a[i] < h[i]*a[j] || (h[j]*a[i] == h[i]*a[j] && j < i)) hr++;
            end
            nice[i] = br - hr;
        end
        m_nbw = 0; mx = -100; mn = 100;
        for (int i = 0; i < N; i++) if (m_lat[i] == 0) begin
            m_nbw++;
            if (nice[i] > mx) mx = nice[i];
            if (nice[i] < mn) mn = nice[i];
            sl = 0;
            for (int j = 0; j < N; j++)
                if (j != i && m_lat[j] == 0 &&
                    (nice[j] > nice[i] || (nice[j] == nice[i] && j < i))) sl++;
            m_slot[i] = sl;
        end
        m_ins = (m_nbw > 1 && mx - mn >= 3) ? 1 : 0;
    endtask

    // Shuffle tick from R8 and R9.
    task automatic model_shuffle();
        int p, q;
        int old [N];
        if (m_nbw > 0) begin
            p = int'(m_lfsr[1:0]) % m_nbw;
            q = int'(m_lfsr[3:2]) % m_nbw;
            for (int i = 0; i < N; i++) old[i] = m_slot[i];
            for (int i = 0; i < N; i++) if (m_lat[i] == 0) begin
                if (m_ins == 1)       m_slot[i] = (old[i] + 1) % m_nbw;
                else if (old[i] == p) m_slot[i] = q;
                else if (old[i] == q) m_slot[i] = p;
            end
        end
        m_lfsr = {m_lfsr[6:0], ^(m_lfsr & 8'hB8)};
    endtask

    task automatic compare_all(input int k);
        int e, act;
        bit [N-1:0] seen;
        string tg;
        seen = '0;
        for (int i = 0; i < N; i++) begin
            chk((k % Q == 0) ? "R3 lat" : "R2 lat", int'(latm[i]), m_lat[i]);
            act = int'(prio[i*2 +: 2]);
            seen[act] = 1'b1;
            if (m_lat[i] == 1) begin
                e = N - 1 - m_ir[i]; tg = "R4 prio";
            end else begin
                e = m_nbw - 1 - m_slot[i];
                if (k < Q)             tg = "R1 prio";
                else if ((k % Q) < S)  tg = "R5/R6 prio";
                else if (m_ins == 1)   tg = "R8 prio";
                else                   tg = "R9 prio";
            end
            chk(tg, act, e);
        end
        chk("R7 mode", int'(insm), m_ins);
        chk("R10 perm", int'(seen), (1 << N) - 1);
    endtask

    initial begin
        set_pattern(0);
        for (int i = 0; i < N; i++) begin m_lat[i] = 0; m_ir[i] = 0; m_slot[i] = i; end
        m_nbw = N; m_ins = 0; m_lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        chk("R1 lat", int'(latm), 0);
        chk("R1 mode", int'(insm), 0);
        for (int i = 0; i < N; i++) chk("R1 prio", int'(prio[i*2 +: 2]), N - 1 - i);
        rst_n = 1'b1;
        for (int k = 1; k <= NQ * Q; k++) begin
            @(posedge clk);
            if (k % Q == 0)            model_quantum();
            else if ((k % Q) % S == 0) model_shuffle();
            @(negedge clk);
            compare_all(k);
            if (k % Q == 0) set_pattern(k / Q);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R2 watchdog expired act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule